// File: doc/BRIEF.md
# Vectored Interrupt Controller with Reset Sequencer

This block sits in front of a small 8-bit processor core and decides when the core must leave its instruction stream. Eleven peripheral event pulses each set a sticky request flag. The sources are an external pin edge, a DAC reload, two timer overflows, a port transition, a base-timer overflow, an LCD frame start, SPI receive and transmit, and UART receive and transmit. Each flag is gated by its own bit in one of two byte-wide enable registers, and by the core's global interrupt-disable flag I. When a source or a software break request wins, the block raises a one-cycle take strobe. With the strobe it presents the 16-bit address of the low vector byte and asks the core to set I. The core then pushes its state and fetches the vector.

The same block qualifies the active-low reset pin. A single low cycle is filtered out. A low level of two or more cycles halts the core and clears the block's registers. When the pin returns high, a fixed six-cycle initialization sequence runs. The block then issues the reset-vector strobe, which also asks the core to set I and clear decimal mode.

Top module: `irq_vector_ctrl`

## Requirements
- R1: The enable registers sit at byte address 0x03E (sources 0..6 in bits 0..6, bit 7 reads 0) and 0x03F (sources 7..10 in bits 0..3, bits 7..4 read 0). Both are writable, and both read 0 after reset or halt. Source numbering is: 0 ext pin, 1 DAC, 2 timer0, 3 timer1, 4 port, 5 base timer, 6 LCD, 7 SPI RX, 8 SPI TX, 9 UART RX, 10 UART TX.
- R2: A one-cycle pulse on `evt_i[k]` sets request flag k whether or not it is enabled. The flags read back at 0x03C (sources 0..6, bits 0..6) and 0x03D (sources 7..10, bits 0..3).
- R3: Writing 1 to a flag bit at 0x03C/0x03D clears that flag, and writing 0 leaves it unchanged. An event in the same cycle as the clear leaves the flag set.
- R4: A hardware source is taken only when its flag and its enable bit are set and `i_flag_i` is 0. With the block idle, `take_o` and `set_i_o` rise one cycle after the cycle in which these conditions hold.
- R5: When several enabled flags are pending, the lowest source number wins.
- R6: The vector (low byte address) per source is: ext 0x7FF8, DAC 0x7FF6, timer0 0x7FF4, timer1 0x7FF2, port 0x7FF0, base timer 0x7FEE, LCD 0x7FEC, SPI RX 0x7FE8, SPI TX 0x7FE6, UART RX 0x7FEA, UART TX 0x7FE4. `vec_addr_o` holds the last vector between strobes.
- R7: A held `brk_req_i` is accepted only while `i_flag_i` is 0. It gives vector 0x7FFE and wins over any pending hardware source.
- R8: `take_o` is high for exactly one cycle. After an interrupt or break strobe, no further strobe is raised until `take_ack_i` has been high for a cycle, even if requests remain pending.
- R9: A reset pin low for one cycle is ignored. Low for two consecutive cycles halts the block: `run_o` drops, flags and enables clear, events and writes are ignored, and no interrupt is taken.
- R10: When the pin is seen high in the halted state, six initialization cycles follow. Then a one-cycle strobe comes with `vec_addr_o`=0x7FFC and both `set_i_o` and `clr_d_o` high. `run_o` rises in the next cycle. The strobe comes seven cycles after the pin is first sampled high.
- R11: The synchronous chip reset `rst` puts the block in the halted state with all flags and enables cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high chip reset |
| rst_pin_n | input | 1 | Active-low reset pin, qualified by minimum low time |
| evt_i | input | 11 | Peripheral event pulses, one per source number |
| bus_addr_i | input | 12 | Register byte address |
| bus_wr_i | input | 1 | Register write strobe |
| bus_wdata_i | input | 8 | Register write data |
| bus_rdata_o | output | 8 | Register read data for `bus_addr_i` |
| i_flag_i | input | 1 | Core's global interrupt-disable flag |
| brk_req_i | input | 1 | Software break request, held until taken |
| take_ack_i | input | 1 | Core acknowledges the last strobe |
| take_o | output | 1 | One-cycle take strobe |
| vec_addr_o | output | 16 | Vector low-byte address |
| set_i_o | output | 1 | Core must set I |
| clr_d_o | output | 1 | Core must clear decimal mode |
| run_o | output | 1 | Core may run (not halted or initializing) |

## Verification
The bench builds the block with a minimum reset-low time of two cycles and six initialization cycles. These are the design values, so both sides of the glitch filter (one low cycle kept running, two low cycles halting) and the exact seven-cycle distance from the pin's rise to the reset-vector strobe are reached directly. With these small values, each halt and restart costs only a few cycles. The bench can therefore run a halt in the middle of a session and confirm that flags and enables come back cleared, and it can also walk every source's vector, the priority order, break handling and the acknowledge hold-off against a per-cycle reference model.

// File: rtl/irq_vc_pkg.sv
package irq_vc_pkg;

    localparam int NUM_SRC   = 11;
    localparam int LO_BITS   = 7;
    localparam int REG_W     = 8;
    localparam int VEC_W     = 16;
    localparam int SRC_IDX_W = $clog2(NUM_SRC);

    localparam logic [VEC_W-1:0] VEC_RESET = 16'h7FFC;
    localparam logic [VEC_W-1:0] VEC_BRK   = 16'h7FFE;

    typedef enum logic [1:0] {
        SEQ_HALT = 2'd0,
        SEQ_INIT = 2'd1,
        SEQ_VEC  = 2'd2,
        SEQ_RUN  = 2'd3
    } seq_state_t;

    typedef struct packed {
        logic                 hit;
        logic [SRC_IDX_W-1:0] idx;
    } pick_t;

    // Vector table, indexed by source number (which is also the priority rank)
    function automatic logic [VEC_W-1:0] src_vector(input logic [SRC_IDX_W-1:0] idx);
        logic [VEC_W-1:0] v;
        case (idx)
            4'd0:    v = 16'h7FF8;
            4'd1:    v = 16'h7FF6;
            4'd2:    v = 16'h7FF4;
            4'd3:    v = 16'h7FF2;
            4'd4:    v = 16'h7FF0;
            4'd5:    v = 16'h7FEE;
            4'd6:    v = 16'h7FEC;
            4'd7:    v = 16'h7FE8;
            4'd8:    v = 16'h7FE6;
            4'd9:    v = 16'h7FEA;
            4'd10:   v = 16'h7FE4;
            default: v = VEC_BRK;
        endcase
        return v;
    endfunction

    // Lowest set index wins
    function automatic pick_t pick_first(input logic [NUM_SRC-1:0] v);
        pick_t r;
        r.hit = 1'b0;
        r.idx = '0;
        for (int k = NUM_SRC - 1; k >= 0; k--) begin
            if (v[k]) begin
                r.hit = 1'b1;
                r.idx = SRC_IDX_W'(k);
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/irq_rst_seq.sv
module irq_rst_seq
    import irq_vc_pkg::*;
#(
    parameter int MIN_LOW  = 2,
    parameter int INIT_CYC = 6
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pin_i,
    output seq_state_t state_o
);

    localparam int LW = $clog2(MIN_LOW + 1);
    localparam int IW = $clog2(INIT_CYC + 1);
    localparam logic [LW-1:0] LOW_SAT   = LW'(MIN_LOW);
    localparam logic [LW-1:0] LOW_ARM   = LW'(MIN_LOW - 1);
    localparam logic [IW-1:0] INIT_LAST = IW'(INIT_CYC - 1);

    logic [LW-1:0] low_q;
    logic [IW-1:0] init_q;
    seq_state_t    state_q;
    seq_state_t    state_d;
    logic          qual_low;

    // Pin is low now and was low for MIN_LOW-1 cycles before
    assign qual_low = !pin_i && (low_q >= LOW_ARM);

    always_comb begin
        state_d = state_q;
        if (qual_low) begin
            state_d = SEQ_HALT;
        end else begin
            case (state_q)
                SEQ_HALT: if (pin_i) state_d = SEQ_INIT;
                SEQ_INIT: if (init_q == INIT_LAST) state_d = SEQ_VEC;
                SEQ_VEC:  state_d = SEQ_RUN;
                default:  state_d = SEQ_RUN;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_HALT;
            low_q   <= '0;
            init_q  <= '0;
        end else begin
            state_q <= state_d;
            if (pin_i)
                low_q <= '0;
            else if (low_q != LOW_SAT)
                low_q <= low_q + LW'(1);
            if (state_q != SEQ_INIT)
                init_q <= '0;
            else
                init_q <= init_q + IW'(1);
        end
    end

    assign state_o = state_q;

    AST_VEC_AFTER_INIT: assert property (@(posedge clk) disable iff (rst)
        (state_q == SEQ_VEC) |-> ($past(state_q) == SEQ_INIT)); // R10

    AST_HIGH_PIN_KEEPS_RUN: assert property (@(posedge clk) disable iff (rst)
        (state_q == SEQ_RUN && pin_i) |=> (state_q == SEQ_RUN)); // R9

    generate
        if (MIN_LOW >= 2) begin : g_glitch_chk
            AST_HALT_NEEDS_TWO_LOW: assert property (@(posedge clk) disable iff (rst)
                (state_q == SEQ_HALT && $past(state_q) != SEQ_HALT)
                |-> (!$past(pin_i) && !$past(pin_i, 2))); // R9
        end
    endgenerate

endmodule

// File: rtl/irq_flag_regs.sv
module irq_flag_regs
    import irq_vc_pkg::*;
#(
    parameter int                ADDR_W     = 12,
    parameter logic [ADDR_W-1:0] FL_LO_ADDR = 12'h03C,
    parameter logic [ADDR_W-1:0] FL_HI_ADDR = 12'h03D,
    parameter logic [ADDR_W-1:0] EN_LO_ADDR = 12'h03E,
    parameter logic [ADDR_W-1:0] EN_HI_ADDR = 12'h03F
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               halted_i,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic [ADDR_W-1:0]  bus_addr_i,
    input  logic               bus_wr_i,
    input  logic [REG_W-1:0]   bus_wdata_i,
    output logic [REG_W-1:0]   bus_rdata_o,
    output logic [NUM_SRC-1:0] pend_o
);

    localparam int HI_BITS = NUM_SRC - LO_BITS;

    logic [NUM_SRC-1:0] flag_q;
    logic [NUM_SRC-1:0] en_q;

    generate
        for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
            localparam bit                IS_LO = (g < LO_BITS);
            localparam int                POS   = IS_LO ? g : g - LO_BITS;
            localparam logic [ADDR_W-1:0] F_ADR = IS_LO ? FL_LO_ADDR : FL_HI_ADDR;
            localparam logic [ADDR_W-1:0] E_ADR = IS_LO ? EN_LO_ADDR : EN_HI_ADDR;

            logic clr_w;
            logic wen_w;

            assign clr_w = bus_wr_i && (bus_addr_i == F_ADR) && bus_wdata_i[POS];
            assign wen_w = bus_wr_i && (bus_addr_i == E_ADR);

            always_ff @(posedge clk) begin
                if (rst || halted_i) begin
                    flag_q[g] <= 1'b0;
                    en_q[g]   <= 1'b0;
                end else begin
                    flag_q[g] <= evt_i[g] | (flag_q[g] & ~clr_w);
                    if (wen_w)
                        en_q[g] <= bus_wdata_i[POS];
                end
            end

            AST_EVT_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
                (!halted_i && evt_i[g]) |=> flag_q[g]); // R2

            AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
                (!halted_i && clr_w && !evt_i[g]) |=> !flag_q[g]); // R3
        end
    endgenerate

    always_comb begin
        if (bus_addr_i == EN_LO_ADDR)
            bus_rdata_o = REG_W'(en_q[LO_BITS-1:0]);
        else if (bus_addr_i == EN_HI_ADDR)
            bus_rdata_o = REG_W'(en_q[NUM_SRC-1:NUM_SRC-HI_BITS]);
        else if (bus_addr_i == FL_LO_ADDR)
            bus_rdata_o = REG_W'(flag_q[LO_BITS-1:0]);
        else if (bus_addr_i == FL_HI_ADDR)
            bus_rdata_o = REG_W'(flag_q[NUM_SRC-1:NUM_SRC-HI_BITS]);
        else
            bus_rdata_o = '0;
    end

    assign pend_o = flag_q & en_q;

    AST_HALT_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        halted_i |=> (pend_o == '0)); // R9

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_vc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               run_i,
    input  logic [NUM_SRC-1:0] pend_i,
    input  logic               brk_i,
    input  logic               i_flag_i,
    input  logic               ack_i,
    output logic               take_o,
    output logic [VEC_W-1:0]   vec_o
);

    pick_t            pick;
    logic             can_take;
    logic [VEC_W-1:0] vec_d;
    logic             take_q;
    logic             busy_q;
    logic [VEC_W-1:0] vec_q;

    assign pick     = pick_first(pend_i);
    assign can_take = run_i && !busy_q && !i_flag_i && (brk_i || pick.hit);
    assign vec_d    = brk_i ? VEC_BRK : src_vector(pick.idx);

    always_ff @(posedge clk) begin
        if (rst) begin
            take_q <= 1'b0;
            busy_q <= 1'b0;
            vec_q  <= '0;
        end else if (!run_i) begin
            take_q <= 1'b0;
            busy_q <= 1'b0;
        end else begin
            take_q <= can_take;
            busy_q <= can_take | (busy_q & ~ack_i);
            if (can_take)
                vec_q <= vec_d;
        end
    end

    assign take_o = take_q;
    assign vec_o  = vec_q;

    AST_TAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        take_q |=> !take_q); // R8

    AST_TAKE_NEEDS_I_CLEAR: assert property (@(posedge clk) disable iff (rst)
        take_q |-> $past(!i_flag_i)); // R4

    AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !ack_i) |=> !take_q); // R8

    AST_VEC_MOVES_ON_TAKE: assert property (@(posedge clk) disable iff (rst)
        !$stable(vec_q) |-> take_q); // R6

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irq_vc_pkg::*;
#(
    parameter int                ADDR_W     = 12,
    parameter int                MIN_LOW    = 2,
    parameter int                INIT_CYC   = 6,
    parameter logic [ADDR_W-1:0] FL_LO_ADDR = 12'h03C,
    parameter logic [ADDR_W-1:0] FL_HI_ADDR = 12'h03D,
    parameter logic [ADDR_W-1:0] EN_LO_ADDR = 12'h03E,
    parameter logic [ADDR_W-1:0] EN_HI_ADDR = 12'h03F
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rst_pin_n,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic [ADDR_W-1:0]  bus_addr_i,
    input  logic               bus_wr_i,
    input  logic [REG_W-1:0]   bus_wdata_i,
    output logic [REG_W-1:0]   bus_rdata_o,
    input  logic               i_flag_i,
    input  logic               brk_req_i,
    input  logic               take_ack_i,
    output logic               take_o,
    output logic [VEC_W-1:0]   vec_addr_o,
    output logic               set_i_o,
    output logic               clr_d_o,
    output logic               run_o
);

    seq_state_t         seq_state;
    logic               halted;
    logic               running;
    logic               rst_take;
    logic [NUM_SRC-1:0] pend;
    logic               arb_take;
    logic [VEC_W-1:0]   arb_vec;

    irq_rst_seq #(
        .MIN_LOW  (MIN_LOW),
        .INIT_CYC (INIT_CYC)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .pin_i   (rst_pin_n),
        .state_o (seq_state)
    );

    assign halted   = (seq_state == SEQ_HALT);
    assign running  = (seq_state == SEQ_RUN);
    assign rst_take = (seq_state == SEQ_VEC);

    irq_flag_regs #(
        .ADDR_W     (ADDR_W),
        .FL_LO_ADDR (FL_LO_ADDR),
        .FL_HI_ADDR (FL_HI_ADDR),
        .EN_LO_ADDR (EN_LO_ADDR),
        .EN_HI_ADDR (EN_HI_ADDR)
    ) u_regs (
        .clk         (clk),
        .rst         (rst),
        .halted_i    (halted),
        .evt_i       (evt_i),
        .bus_addr_i  (bus_addr_i),
        .bus_wr_i    (bus_wr_i),
        .bus_wdata_i (bus_wdata_i),
        .bus_rdata_o (bus_rdata_o),
        .pend_o      (pend)
    );

    irq_arbiter u_arb (
        .clk      (clk),
        .rst      (rst),
        .run_i    (running),
        .pend_i   (pend),
        .brk_i    (brk_req_i),
        .i_flag_i (i_flag_i),
        .ack_i    (take_ack_i),
        .take_o   (arb_take),
        .vec_o    (arb_vec)
    );

    assign take_o     = rst_take | (arb_take & running);
    assign vec_addr_o = rst_take ? VEC_RESET : arb_vec;
    assign set_i_o    = take_o;
    assign clr_d_o    = rst_take;
    assign run_o      = running;

endmodule

// File: tb/irq_vector_ctrl_bench.sv
module irq_vector_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int MIN_LOW    = 2;
    localparam int INIT_CYC   = 6;
    localparam int WD_LIMIT   = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rst_pin_n = 1'b0;
    logic [10:0] evt_i = '0;
    logic [11:0] bus_addr_i = 12'h03E;
    logic        bus_wr_i = 1'b0;
    logic [7:0]  bus_wdata_i = '0;
    logic [7:0]  bus_rdata_o;
    logic        i_flag_i = 1'b1;
    logic        brk_req_i = 1'b0;
    logic        take_ack_i = 1'b0;
    logic        take_o;
    logic [15:0] vec_addr_o;
    logic        set_i_o;
    logic        clr_d_o;
    logic        run_o;

    int total = 0;
    int bad = 0;
    int wd_cnt = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    irq_vector_ctrl #(
        .MIN_LOW  (MIN_LOW),
        .INIT_CYC (INIT_CYC)
    ) u_irq_vector_ctrl (
        .clk         (clk),
        .rst         (rst),
        .rst_pin_n   (rst_pin_n),
        .evt_i       (evt_i),
        .bus_addr_i  (bus_addr_i),
        .bus_wr_i    (bus_wr_i),
        .bus_wdata_i (bus_wdata_i),
        .bus_rdata_o (bus_rdata_o),
        .i_flag_i    (i_flag_i),
        .brk_req_i   (brk_req_i),
        .take_ack_i  (take_ack_i),
        .take_o      (take_o),
        .vec_addr_o  (vec_addr_o),
        .set_i_o     (set_i_o),
        .clr_d_o     (clr_d_o),
        .run_o       (run_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    int vt[11] = '{'h7FF8, 'h7FF6, 'h7FF4, 'h7FF2, 'h7FF0, 'h7FEE,
                   'h7FEC, 'h7FE8, 'h7FE6, 'h7FEA, 'h7FE4};
    int          m_st = 0;   // 0 halted, 1 init, 2 reset strobe, 3 running
    int          m_low = 0;
    int          m_init = 0;
    logic [10:0] m_fl = '0;
    logic [10:0] m_en = '0;
    logic        m_take = 1'b0;
    logic        m_busy = 1'b0;
    int          m_vec = 0;

    always @(posedge clk) begin
        int          nst;
        int          first;
        logic        can;
        logic [10:0] pend;
        logic [10:0] clrm;
        logic [10:0] nfl;
        logic [10:0] nen;
        if (rst) begin
            m_st = 0; m_low = 0; m_init = 0; m_fl = '0; m_en = '0;
            m_take = 1'b0; m_busy = 1'b0; m_vec = 0;
        end else begin
            pend = m_fl & m_en;
            first = -1;
            for (int k = 10; k >= 0; k--) if (pend[k]) first = k;
            can = (m_st == 3) && !m_busy && !i_flag_i && (brk_req_i || first >= 0);
            if (can) m_vec = brk_req_i ? 'h7FFE : vt[first];
            m_busy = (m_st == 3) && (can || (m_busy && !take_ack_i));
            m_take = can;
            if (m_st == 0) begin
                nfl = '0; nen = '0;
            end else begin
                clrm = '0;
                nen = m_en;
                if (bus_wr_i && bus_addr_i == 12'h03C) clrm[6:0]  = bus_wdata_i[6:0];
                if (bus_wr_i && bus_addr_i == 12'h03D) clrm[10:7] = bus_wdata_i[3:0];
                if (bus_wr_i && bus_addr_i == 12'h03E) nen[6:0]   = bus_wdata_i[6:0];
                if (bus_wr_i && bus_addr_i == 12'h03F) nen[10:7]  = bus_wdata_i[3:0];
                nfl = evt_i | (m_fl & ~clrm);
            end
            m_fl = nfl;
            m_en = nen;
            if (!rst_pin_n && m_low >= MIN_LOW - 1) nst = 0;
            else if (m_st == 0) nst = rst_pin_n ? 1 : 0;
            else if (m_st == 1) nst = (m_init == INIT_CYC - 1) ? 2 : 1;
            else nst = 3;
            m_init = (m_st == 1) ? m_init + 1 : 0;
            m_low  = rst_pin_n ? 0 : ((m_low < MIN_LOW) ? m_low + 1 : m_low);
            m_st   = nst;
        end
    end

    function automatic int model_rd(input logic [11:0] a);
        case (a)
            12'h03E: return int'(m_en[6:0]);
            12'h03F: return int'(m_en[10:7]);
            12'h03C: return int'(m_fl[6:0]);
            12'h03D: return int'(m_fl[10:7]);
            default: return 0;
        endcase
    endfunction

    always @(negedge clk) begin
        if (!rst) begin
            chk("R8",  "model take",   int'(take_o),  int'((m_st == 2) || (m_take && m_st == 3)));
            chk("R6",  "model vector", int'(vec_addr_o), (m_st == 2) ? 'h7FFC : m_vec);
            chk("R4",  "model set_i",  int'(set_i_o), int'((m_st == 2) || (m_take && m_st == 3)));
            chk("R10", "model clr_d",  int'(clr_d_o), int'(m_st == 2));
            chk("R9",  "model run",    int'(run_o),   int'(m_st == 3));
            chk("R2",  "model rdata",  int'(bus_rdata_o), model_rd(bus_addr_i));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [11:0] a, input logic [7:0] d);
        bus_addr_i = a; bus_wdata_i = d; bus_wr_i = 1'b1;
        step(1);
        bus_wr_i = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output int v);
        bus_addr_i = a;
        #1;
        v = int'(bus_rdata_o);
    endtask

    task automatic pulse(input logic [10:0] m);
        evt_i = m;
        step(1);
        evt_i = '0;
    endtask

    task automatic wait_take(output int vec, output int cyc);
        cyc = 0;
        while (!take_o && cyc < 60) begin
            step(1);
            cyc++;
        end
        vec = int'(vec_addr_o);
    endtask

    task automatic count_takes(input int n, output int c);
        c = 0;
        for (int k = 0; k < n; k++) begin
            step(1);
            if (take_o) c++;
        end
    endtask

    task automatic ack_and_mask();
        take_ack_i = 1'b1; i_flag_i = 1'b1;
        step(1);
        take_ack_i = 1'b0;
    endtask

    task automatic clear_all();
        wr(12'h03C, 8'h7F);
        wr(12'h03D, 8'h0F);
    endtask

    always @(posedge clk) begin
        wd_cnt++;
        if (wd_cnt > WD_LIMIT) begin
            total++; bad++;
            $display("FAIL watchdog act=%0d exp<%0d cycles", wd_cnt, WD_LIMIT);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int v, c, n;
        step(3);
        rst = 1'b0;
        step(1);
        chk("R11", "run after chip reset", int'(run_o), 0);
        rd(12'h03E, v); chk("R11", "enables after reset", v, 0);

        // R10: init sequence length and reset vector
        rst_pin_n = 1'b1;
        wait_take(v, n);
        chk("R10", "cycles pin-high to reset strobe", n, INIT_CYC + 1);
        chk("R10", "reset vector", v, 'h7FFC);
        chk("R10", "clr_d on reset strobe", int'(clr_d_o), 1);
        chk("R10", "set_i on reset strobe", int'(set_i_o), 1);
        step(1);
        chk("R10", "run after reset strobe", int'(run_o), 1);

        // R1: enable registers and unimplemented bits
        wr(12'h03E, 8'hFF); rd(12'h03E, v); chk("R1", "low enable readback", v, 'h7F);
        wr(12'h03F, 8'hFF); rd(12'h03F, v); chk("R1", "high enable readback", v, 'h0F);

        // R2, R4: flag sets while masked, no take while I set
        pulse(11'h004);
        rd(12'h03C, v); chk("R2", "timer0 flag set", v, 'h04);
        count_takes(4, c); chk("R4", "no take while I set", c, 0);
        i_flag_i = 1'b0;
        wait_take(v, n);
        chk("R4", "take latency after I clear", n, 1);
        chk("R6", "timer0 vector", v, 'h7FF4);
        // R8: one-cycle strobe, hold until ack
        step(1);
        chk("R8", "strobe one cycle", int'(take_o), 0);
        count_takes(5, c); chk("R8", "no strobe before ack", c, 0);
        take_ack_i = 1'b1; step(1); take_ack_i = 1'b0;
        wait_take(v, n);
        chk("R8", "strobe resumes after ack", n, 1);
        ack_and_mask();

        // R3: write-one-to-clear, event wins over clear
        wr(12'h03C, 8'h00); rd(12'h03C, v); chk("R3", "write 0 keeps flag", v, 'h04);
        wr(12'h03C, 8'h04); rd(12'h03C, v); chk("R3", "write 1 clears flag", v, 0);
        evt_i = 11'h001;
        wr(12'h03C, 8'h01);
        evt_i = '0;
        rd(12'h03C, v); chk("R3", "event beats clear", v, 'h01);
        clear_all();

        // R4: disabled source not taken
        wr(12'h03E, 8'h7D);
        pulse(11'h002);
        i_flag_i = 1'b0;
        count_takes(5, c); chk("R4", "disabled DAC not taken", c, 0);
        i_flag_i = 1'b1;
        wr(12'h03E, 8'h7F);
        clear_all();

        // R6: every source vector
        for (int k = 0; k < 11; k++) begin
            pulse(11'(1 << k));
            i_flag_i = 1'b0;
            wait_take(v, n);
            chk("R6", $sformatf("vector of source %0d", k), v, vt[k]);
            ack_and_mask();
            clear_all();
        end

        // R5: priority among several pending
        pulse(11'h290);   // sources 4, 7, 9
        i_flag_i = 1'b0;
        wait_take(v, n); chk("R5", "port beats SPI RX and UART RX", v, 'h7FF0);
        ack_and_mask();
        wr(12'h03C, 8'h10);
        i_flag_i = 1'b0;
        wait_take(v, n); chk("R5", "SPI RX beats UART RX", v, 'h7FE8);
        ack_and_mask();
        wr(12'h03D, 8'h01);
        i_flag_i = 1'b0;
        wait_take(v, n); chk("R5", "UART RX last", v, 'h7FEA);
        ack_and_mask();
        clear_all();

        // R7: break request
        brk_req_i = 1'b1;
        pulse(11'h001);
        count_takes(4, c); chk("R7", "break held off by I", c, 0);
        i_flag_i = 1'b0;
        wait_take(v, n); chk("R7", "break vector wins over ext", v, 'h7FFE);
        brk_req_i = 1'b0;
        ack_and_mask();
        i_flag_i = 1'b0;
        wait_take(v, n); chk("R7", "ext after break", v, 'h7FF8);
        ack_and_mask();

        // R9: glitch filter and halt
        rst_pin_n = 1'b0; step(1); rst_pin_n = 1'b1;
        step(2);
        chk("R9", "one-cycle low ignored", int'(run_o), 1);
        rd(12'h03E, v); chk("R9", "enables kept after glitch", v, 'h7F);
        rst_pin_n = 1'b0;
        step(2);
        chk("R9", "two-cycle low halts", int'(run_o), 0);
        pulse(11'h7FF);
        i_flag_i = 1'b0;
        count_takes(3, c); chk("R9", "no take while halted", c, 0);
        rd(12'h03C, v); chk("R9", "events ignored while halted", v, 0);
        rd(12'h03E, v); chk("R9", "enables cleared by halt", v, 0);
        i_flag_i = 1'b1;
        rst_pin_n = 1'b1;
        wait_take(v, n);
        chk("R10", "restart strobe distance", n, INIT_CYC + 1);
        chk("R10", "restart vector", v, 'h7FFC);
        step(2);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule